// File: doc/BRIEF.md
# Event-Stepped Two-Wire Bus Master

This block is a byte-level master for an I2C bus. Software moves it forward one bus event at a time: a START, a repeated START, an address byte, a data byte sent or received, or a STOP. After each event except a STOP, the controller raises an interrupt flag and posts a status code that names the bus state it reached. While the flag is set, it holds SCL low. Software clears the flag with a control write, and that write also chooses the next action.

The register port is synchronous. Writes take effect on the clock edge where `reg_wr` is high, and reads are combinational from `reg_addr`. There are four registers:
- Offset 0 is control. Bit 7 is interrupt enable, bit 6 is controller enable, bit 5 is start, bit 4 is stop, bit 3 is the interrupt flag and bit 2 is the acknowledge select. Bits 1:0 always read 0.
- Offset 1 is data.
- Offset 2 returns the status code on reads. On writes it sets the bus rate.
- Offset 3 is a soft reset on any write, and it reads 0.

The open-drain lines are modelled as two pull-low outputs with matching line inputs. Only 7-bit addressing is supported, and the block always acts as the single master.

Top module: `twi_event_master`

## Requirements
- R1: After reset, control reads 0x00, status reads 0xF8, `irq` is low, and neither line is pulled low.
- R2: `irq` is high exactly when interrupt enable (control bit 7) and the interrupt flag (control bit 3) are both set. Control reads back as {ien, en, sta, sto, flag, ack, 2'b00}.
- R3: With the controller enabled, clearing the flag while start is set and the bus is free produces a START (SDA falls while SCL is high). The result is status 0x08, a set flag, start cleared, and SCL then held low while the flag stays set.
- R4: A byte sent right after a START or repeated START is an address, and data bit 0 is the read/write bit. The status codes are 0x18 (write, ACK), 0x20 (write, NACK), 0x40 (read, ACK) and 0x48 (read, NACK).
- R5: A data byte sent after a write address goes out MSB first, with SDA changing only while SCL is low. The status is 0x28 on ACK and 0x30 on NACK.
- R6: After a read address, each step receives one byte MSB first into the data register. The master drives ACK if control bit 2 is set when the byte starts (status 0x50), and NACK otherwise (status 0x58).
- R7: Start set while the bus is owned produces a repeated START with no STOP, and status 0x10.
- R8: Stop set while the bus is owned, with the flag cleared, produces a STOP (SDA rises while SCL is high). The block then releases both lines, leaves the flag clear, reads status 0xF8, and clears start and stop.
- R9: When start and stop are both set while the bus is owned, a STOP comes first and then a fresh START. The status is 0x08, not 0x10.
- R10: If SCL or SDA is low when a START is attempted, status becomes 0x00 and the flag is set. The bus is not taken, and both lines stay released.
- R11: Any write to offset 3 returns the block to idle. Control is cleared and both lines are released, but the rate setting is kept.
- R12: The rate byte written at offset 2 splits into M = bits 6:3 and N = bits 2:0. One SCL period lasts 10·(M+1)·2^N clocks. The reset setting is M=15, N=7, so a START lasts 10·2048 clocks.
- R13: Writing the flag as 1 leaves it unchanged. Only writing 0 clears it. No bus action begins while the flag is set or while the enable bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq | output | 1 | Interrupt request |
| scl_in | input | 1 | Sensed SCL level |
| sda_in | input | 1 | Sensed SDA level |
| scl_pull | output | 1 | Pull SCL low when high |
| sda_pull | output | 1 | Pull SDA low when high |

## Verification
The STOP and START requests can fall on the same control write. That write clears the flag with both the start and stop bits set while the bus is owned. The bus model counts STOP and START conditions separately, so the check expects exactly one of each, in that order. It also expects the status to come back as 0x08 rather than the 0x10 of a repeated START, and it expects start and stop to read back cleared afterwards.

// File: rtl/twi_event_master.sv
`timescale 1ns/1ps
module twi_event_master (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_pull,
  output logic       sda_pull
);
  typedef enum logic [2:0] {S_IDLE, S_STA, S_RSTA, S_BYTE, S_STOP} st_t;

  st_t        st;
  logic [6:0] rate;
  logic       ien, en, sta, sto, iflg, aak;
  logic       owned, addrb, rxm, ackr;
  logic [7:0] dat, sh, stat;
  logic [3:0] ph, bn;
  logic [11:0] cnt, pre;
  logic       srst, rxd;

  assign srst = reg_wr && reg_addr == 2'd3;
  assign rxd  = rxm && !addrb;
  assign pre  = (({8'd0, rate[6:3]} + 12'd1) << rate[2:0]) - 12'd1;
  assign irq  = ien && iflg;
  assign reg_rdata = reg_addr == 2'd0 ? {ien, en, sta, sto, iflg, aak, 2'b00} :
                     reg_addr == 2'd1 ? dat :
                     reg_addr == 2'd2 ? (iflg ? stat : 8'hF8) : 8'h00;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rate <= 7'h7F;
    else if (reg_wr && reg_addr == 2'd2) rate <= reg_wdata[6:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ien, en, sta, sto, iflg, aak} <= '0;
      {owned, addrb, rxm, ackr, scl_pull, sda_pull} <= '0;
      dat <= '0; sh <= '0; stat <= 8'hF8; st <= S_IDLE;
      ph <= '0; bn <= '0; cnt <= '0;
    end else if (srst) begin
      {ien, en, sta, sto, iflg, aak} <= '0;
      {owned, addrb, rxm, ackr, scl_pull, sda_pull} <= '0;
      stat <= 8'hF8; st <= S_IDLE; ph <= '0; bn <= '0; cnt <= '0;
    end else begin
      if (reg_wr && reg_addr == 2'd1) dat <= reg_wdata;
      if (reg_wr && reg_addr == 2'd0) begin
        ien <= reg_wdata[7]; en <= reg_wdata[6]; sta <= reg_wdata[5];
        sto <= reg_wdata[4]; aak <= reg_wdata[2];
        if (!reg_wdata[3]) iflg <= 1'b0;
      end
      if (st == S_IDLE) begin
        if (en && !iflg) begin
          cnt <= pre; ph <= '0; bn <= '0;
          if (sto && owned) st <= S_STOP;
          else if (sta) st <= owned ? S_RSTA : S_STA;
          else if (owned) begin st <= S_BYTE; sh <= rxd ? 8'hFF : dat; end
          else sto <= 1'b0;
        end
      end else if (cnt != 12'd0) begin
        cnt <= cnt - 12'd1;
      end else begin
        cnt <= pre;
        ph  <= (ph == 4'd9) ? 4'd0 : ph + 4'd1;
        case (st)
          S_STA:
            if (ph == 4'd0 && !(scl_in && sda_in)) begin
              st <= S_IDLE; sta <= 1'b0; stat <= 8'h00; iflg <= 1'b1;
            end else if (ph == 4'd5) sda_pull <= 1'b1;
            else if (ph == 4'd9) begin
              scl_pull <= 1'b1; owned <= 1'b1; addrb <= 1'b1; sta <= 1'b0; sto <= 1'b0;
              stat <= 8'h08; iflg <= 1'b1; st <= S_IDLE;
            end
          S_RSTA:
            if (ph == 4'd0) sda_pull <= 1'b0;
            else if (ph == 4'd3) scl_pull <= 1'b0;
            else if (ph == 4'd6) sda_pull <= 1'b1;
            else if (ph == 4'd9) begin
              scl_pull <= 1'b1; addrb <= 1'b1; sta <= 1'b0;
              stat <= 8'h10; iflg <= 1'b1; st <= S_IDLE;
            end
          S_STOP:
            if (ph == 4'd0) sda_pull <= 1'b1;
            else if (ph == 4'd3) scl_pull <= 1'b0;
            else if (ph == 4'd6) sda_pull <= 1'b0;
            else if (ph == 4'd9) begin
              owned <= 1'b0; sto <= 1'b0; stat <= 8'hF8; st <= S_IDLE;
            end
          S_BYTE:
            if (ph == 4'd0) sda_pull <= (bn < 4'd8) ? (!rxd && !sh[7]) : (rxd && aak);
            else if (ph == 4'd5) scl_pull <= 1'b0;
            else if (ph == 4'd7) begin
              if (bn < 4'd8) sh <= {sh[6:0], sda_in};
              else ackr <= !sda_in;
            end else if (ph == 4'd9) begin
              scl_pull <= 1'b1;
              if (bn == 4'd8) begin
                sda_pull <= 1'b0; dat <= sh; iflg <= 1'b1; st <= S_IDLE;
                if (addrb) begin
                  rxm <= sh[0]; addrb <= 1'b0;
                  stat <= sh[0] ? (ackr ? 8'h40 : 8'h48) : (ackr ? 8'h18 : 8'h20);
                end else if (rxd) stat <= ackr ? 8'h50 : 8'h58;
                else stat <= ackr ? 8'h28 : 8'h30;
              end else bn <= bn + 4'd1;
            end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  AST_HOLD_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    (iflg && owned) |-> scl_pull) else $error("SCL not held during pending event"); // R3
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (iflg && !srst && !(reg_wr && reg_addr == 2'd0 && !reg_wdata[3])) |=> iflg)
    else $error("flag cleared without a zero write"); // R13
  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !owned) |-> (!scl_pull && !sda_pull)) else $error("line driven while bus free"); // R8
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iflg) |-> (stat inside {8'h00, 8'h08, 8'h10, 8'h18, 8'h20, 8'h28,
                                  8'h30, 8'h40, 8'h48, 8'h50, 8'h58}))
    else $error("illegal status code posted"); // R4
  AST_SDA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BYTE && ph >= 4'd6) |-> $stable(sda_pull)) else $error("SDA moved while SCL high"); // R5
endmodule

// File: tb/tb_twi_event_master.sv
`timescale 1ns/1ps
module tb_twi_event_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic irq, scl_pull, sda_pull;
  logic s_drv = 1'b0, force_low = 1'b0;
  wire scl = !scl_pull;
  wire sda = !(sda_pull || s_drv || force_low);

  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  twi_event_master dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_in(scl), .sda_in(sda), .scl_pull(scl_pull), .sda_pull(sda_pull));

  // bus target at 7-bit address 0x50: NACKs written byte 0xFF, reads A5 then rotate-left
  logic scl_q = 1'b1, sda_q = 1'b1;
  logic s_act = 1'b0, s_addr = 1'b0, s_sel = 1'b0, s_rd = 1'b0, s_mack = 1'b0;
  logic [3:0] s_cnt = 4'd0;
  logic [7:0] s_sh = 8'h00, s_rb = 8'hA5, s_last = 8'h00, s_nb;
  int n_start = 0, n_stop = 0;
  int p_cnt = 0, last_per = 0;

  always @(posedge clk) begin
    scl_q <= scl; sda_q <= sda;
    if (scl && !scl_q) begin last_per <= p_cnt; p_cnt <= 1; end
    else p_cnt <= p_cnt + 1;
    if (!rst_n) begin
      s_act <= 1'b0; s_drv <= 1'b0;
    end else if (scl && scl_q && sda_q && !sda) begin
      s_act <= 1'b1; s_cnt <= 4'd0; s_addr <= 1'b1; s_sel <= 1'b0; s_rd <= 1'b0;
      s_drv <= 1'b0; s_rb <= 8'hA5; n_start <= n_start + 1;
    end else if (scl && scl_q && !sda_q && sda) begin
      s_act <= 1'b0; s_drv <= 1'b0; n_stop <= n_stop + 1;
    end else if (s_act && scl && !scl_q) begin
      if (s_cnt < 4'd8) begin s_sh <= {s_sh[6:0], sda}; s_cnt <= s_cnt + 4'd1; end
      else if (s_cnt == 4'd8) begin s_mack <= !sda; s_cnt <= 4'd9; end
    end else if (s_act && !scl && scl_q) begin
      if (s_cnt == 4'd8) begin
        if (s_addr) begin
          s_sel <= (s_sh[7:1] == 7'h50); s_rd <= s_sh[0]; s_drv <= (s_sh[7:1] == 7'h50);
        end else if (s_sel && !s_rd) begin
          s_drv <= (s_sh != 8'hFF);
          if (s_sh != 8'hFF) s_last <= s_sh;
        end else s_drv <= 1'b0;
      end else if (s_cnt == 4'd9) begin
        s_cnt <= 4'd0; s_addr <= 1'b0;
        if (s_sel && s_rd && (s_addr || s_mack)) begin
          s_nb = s_addr ? s_rb : {s_rb[6:0], s_rb[7]};
          s_rb <= s_nb; s_drv <= !s_nb[7];
        end else begin
          s_drv <= 1'b0;
          if (s_rd) s_sel <= 1'b0;
        end
      end else if (s_sel && s_rd && !s_addr && s_cnt >= 4'd1 && s_cnt <= 4'd7)
        s_drv <= !s_rb[3'd7 - s_cnt[2:0]];
    end
  end

  task automatic check(input int req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_flag(input int req, output int n);
    logic [7:0] v;
    n = 0;
    do begin rd(2'd0, v); n++; end while (!v[3] && n < 30000);
    if (!v[3]) check(req, 0, 1, "flag never set");
  endtask

  task automatic pause(input int k);
    repeat (k) @(negedge clk);
  endtask

  localparam int NV = 53;
  localparam logic [1:0] W = 2'd0, RD = 2'd1, F = 2'd2, P = 2'd3;
  // {req, op, offset, write data, expected}
  localparam logic [23:0] VEC [0:NV-1] = '{
    {4'd12, W, 2'd2, 8'h00, 8'h00},                                  // R12 fastest rate
    {4'd3, W, 2'd0, 8'hE0, 8'h00}, {4'd3, F, 2'd0, 8'h00, 8'h00},    // R3 START
    {4'd3, RD, 2'd2, 8'h00, 8'h08}, {4'd13, RD, 2'd0, 8'h00, 8'hC8}, // R3 R13
    {4'd4, W, 2'd1, 8'hA0, 8'h00}, {4'd4, W, 2'd0, 8'hC0, 8'h00},    // R4 write address
    {4'd4, F, 2'd0, 8'h00, 8'h00}, {4'd4, RD, 2'd2, 8'h00, 8'h18},
    {4'd5, W, 2'd1, 8'h3C, 8'h00}, {4'd5, W, 2'd0, 8'hC0, 8'h00},    // R5 data ACK
    {4'd5, F, 2'd0, 8'h00, 8'h00}, {4'd5, RD, 2'd2, 8'h00, 8'h28},
    {4'd5, W, 2'd1, 8'hFF, 8'h00}, {4'd5, W, 2'd0, 8'hC0, 8'h00},    // R5 data NACK
    {4'd5, F, 2'd0, 8'h00, 8'h00}, {4'd5, RD, 2'd2, 8'h00, 8'h30},
    {4'd7, W, 2'd0, 8'hE0, 8'h00}, {4'd7, F, 2'd0, 8'h00, 8'h00},    // R7 repeated START
    {4'd7, RD, 2'd2, 8'h00, 8'h10},
    {4'd4, W, 2'd1, 8'hA1, 8'h00}, {4'd4, W, 2'd0, 8'hC4, 8'h00},    // R4 read address
    {4'd4, F, 2'd0, 8'h00, 8'h00}, {4'd4, RD, 2'd2, 8'h00, 8'h40},
    {4'd6, W, 2'd0, 8'hC4, 8'h00}, {4'd6, F, 2'd0, 8'h00, 8'h00},    // R6 receive with ACK
    {4'd6, RD, 2'd2, 8'h00, 8'h50}, {4'd6, RD, 2'd1, 8'h00, 8'hA5},
    {4'd6, W, 2'd0, 8'hC0, 8'h00}, {4'd6, F, 2'd0, 8'h00, 8'h00},    // R6 receive with NACK
    {4'd6, RD, 2'd2, 8'h00, 8'h58}, {4'd6, RD, 2'd1, 8'h00, 8'h4B},
    {4'd8, W, 2'd0, 8'hD0, 8'h00}, {4'd8, P, 2'd0, 8'h00, 8'h00},    // R8 STOP
    {4'd8, RD, 2'd2, 8'h00, 8'hF8}, {4'd8, RD, 2'd0, 8'h00, 8'hC0},
    {4'd3, W, 2'd0, 8'hE0, 8'h00}, {4'd3, F, 2'd0, 8'h00, 8'h00},
    {4'd3, RD, 2'd2, 8'h00, 8'h08},
    {4'd4, W, 2'd1, 8'h90, 8'h00}, {4'd4, W, 2'd0, 8'hC0, 8'h00},    // R4 write address NACK
    {4'd4, F, 2'd0, 8'h00, 8'h00}, {4'd4, RD, 2'd2, 8'h00, 8'h20},
    {4'd7, W, 2'd0, 8'hE0, 8'h00}, {4'd7, F, 2'd0, 8'h00, 8'h00},
    {4'd7, RD, 2'd2, 8'h00, 8'h10},
    {4'd4, W, 2'd1, 8'h93, 8'h00}, {4'd4, W, 2'd0, 8'hC0, 8'h00},    // R4 read address NACK
    {4'd4, F, 2'd0, 8'h00, 8'h00}, {4'd4, RD, 2'd2, 8'h00, 8'h48},
    {4'd8, W, 2'd0, 8'hD0, 8'h00}, {4'd8, P, 2'd0, 8'h00, 8'h00},
    {4'd8, RD, 2'd2, 8'h00, 8'hF8}
  };

  initial begin
    logic [7:0] v;
    int n, st0, sp0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, v); check(1, v, 8'h00, "control after reset");
    rd(2'd2, v); check(1, v, 8'hF8, "status after reset");
    check(1, irq, 0, "irq after reset");
    check(1, {scl_pull, sda_pull}, 0, "lines after reset");

    // R12 slowest reset rate: START spans ten ticks of 2048 clocks
    wr(2'd0, 8'hE0);
    wait_flag(12, n);
    check(12, (n >= 20480 && n <= 20500) ? 1 : 0, 1, "reset-rate START length in range");
    // R11 soft reset while holding the bus
    wr(2'd3, 8'h00);
    rd(2'd0, v); check(11, v, 8'h00, "control after soft reset");
    rd(2'd2, v); check(11, v, 8'hF8, "status after soft reset");
    check(11, {irq, scl_pull, sda_pull}, 0, "irq and lines after soft reset");

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][19:18])
        W:  wr(VEC[i][17:16], VEC[i][15:8]);
        RD: begin rd(VEC[i][17:16], v); check(int'(VEC[i][23:20]), v, VEC[i][7:0], $sformatf("vector %0d", i)); end
        F:  wait_flag(int'(VEC[i][23:20]), n);
        default: pause(60);
      endcase
    end
    check(5, s_last, 8'h3C, "target captured byte MSB first"); // R5

    // R2 interrupt gating, R13 flag written as one stays set
    wr(2'd0, 8'h60);
    wait_flag(2, n);
    check(2, irq, 0, "irq masked with enable clear");
    rd(2'd0, v); check(2, v, 8'h48, "control readback");
    wr(2'd0, 8'hC8);
    check(2, irq, 1, "irq with enable and flag");
    pause(40);
    rd(2'd2, v); check(13, v, 8'h08, "no action while flag set");
    check(3, scl_pull, 1, "SCL held during pending event"); // R3

    // R9 stop and start together while owned
    st0 = n_start; sp0 = n_stop;
    wr(2'd0, 8'hF0);
    wait_flag(9, n);
    rd(2'd2, v); check(9, v, 8'h08, "fresh START code");
    check(9, n_stop - sp0, 1, "one STOP seen");
    check(9, n_start - st0, 1, "one START seen");
    rd(2'd0, v); check(9, v, 8'hC8, "start and stop cleared");
    wr(2'd0, 8'hD0); pause(60);

    // R13 disabled controller ignores start
    st0 = n_start;
    wr(2'd0, 8'h20); pause(60);
    rd(2'd2, v); check(13, v, 8'hF8, "disabled status");
    check(13, n_start - st0, 0, "no START while disabled");
    check(13, scl_pull, 0, "SCL released while disabled");
    wr(2'd0, 8'h00);

    // R10 bus error when SDA is held low
    force_low = 1'b1;
    wr(2'd0, 8'hE0);
    wait_flag(10, n);
    rd(2'd2, v); check(10, v, 8'h00, "bus error code");
    check(10, {scl_pull, sda_pull}, 0, "lines released on bus error");
    force_low = 1'b0;
    wr(2'd0, 8'hC0); pause(60);
    rd(2'd2, v); check(10, v, 8'hF8, "idle after error cleared");

    // R12 rate M=1 N=1: 40 clocks per SCL period; R11 rate kept over soft reset
    wr(2'd2, 8'h09);
    wr(2'd0, 8'hE0); wait_flag(12, n);
    wr(2'd1, 8'hA0); wr(2'd0, 8'hC0); wait_flag(12, n);
    rd(2'd2, v); check(12, v, 8'h18, "address at slower rate");
    check(12, last_per, 40, "SCL period");
    wr(2'd3, 8'h00);
    check(11, scl_pull, 0, "SCL released by soft reset");
    wr(2'd0, 8'hE0); wait_flag(11, n);
    wr(2'd1, 8'hA0); wr(2'd0, 8'hC0); wait_flag(11, n);
    check(11, last_per, 40, "rate kept over soft reset");
    wr(2'd0, 8'hD0); pause(120);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule